// File: doc/BRIEF.md
# Conditional Branch Immediate Evaluator

This unit carries out the arithmetic half of a conditional branch in a virtual machine with 64-bit integer registers. Each instruction supplies a 32-bit immediate, a 4-bit condition selector and the present value of the destination register. The unit derives a bit position from the selector and reshapes the immediate into a 64-bit constant. It adds that constant to the register and decides whether the branch is taken by checking whether a fixed-width window of the sum, starting at the derived position, is all zero.

The unit forces one bit of the constant to 1 and clears the bit just below it. Because of this, the register keeps moving through the tested window from one execution to the next. The updated register value is always produced, so the caller writes it back whether or not the branch is taken. The caller computes the jump target index and hands it in. The unit returns that index only when the branch is taken. Inputs are accepted on a valid strobe, and all results appear on registered outputs one clock later.

Top module: `cbr_eval`

## Requirements
- R1: While reset is held low at a clock edge, the next state has out_valid, out_sum, out_taken and out_target all zero.
- R2: out_valid is high in exactly the cycle after a cycle in which in_valid was high, and low otherwise.
- R3: The bit position is b = in_cond + 8, with in_cond unsigned. The constant is the immediate sign-extended to 64 bits, then bit b is set to 1 and bit b-1 is cleared to 0. out_sum equals in_dst plus this constant.
- R4: Bits 63 down to 32 of the constant are copies of immediate bit 31. The addition wraps modulo 2^64 and no carry is kept.
- R5: out_taken is 1 exactly when bits b through b+7 of out_sum are all zero. With in_cond = 15 this is the mask 0x7F800000, and with in_cond = 4 it is the mask 0x000FF000.
- R6: out_sum carries the updated register value whether the branch is taken or not.
- R7: out_target equals the captured in_target when the branch is taken, and is zero when it is not.
- R8: In a cycle without in_valid, out_sum, out_taken and out_target keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe that marks the inputs as an instruction to evaluate |
| in_imm | input | 32 | Branch immediate |
| in_cond | input | 4 | Condition selector; sets the window position |
| in_dst | input | 64 | Current destination register value |
| in_target | input | 8 | Jump target index supplied by the caller |
| out_valid | output | 1 | Results below belong to the instruction of the previous cycle |
| out_sum | output | 64 | Updated destination register value |
| out_taken | output | 1 | Branch decision |
| out_target | output | 8 | Target index when taken, zero otherwise |

## Verification
Every result is due exactly one clock after the edge that captures in_valid. The bench therefore drives each instruction just after a falling edge and reads all four outputs at the following falling edge, with the single capturing rising edge in between. Idle cycles are then inserted to confirm that out_valid drops and the other outputs hold their values. Expected sums and decisions come from bench functions that rebuild the constant and the window from R3 to R5. The stimulus mixes random values, with half of the cases steered into a zero window, and directed cases for sign extension, wrap-around and the two quoted masks.

// File: rtl/cbr_pkg.sv
// Package: default widths and constants shared by the branch evaluator.
// Assumes: nothing beyond standard SystemVerilog.
package cbr_pkg;
    localparam int CBR_DATA_W      = 64;
    localparam int CBR_IMM_W       = 32;
    localparam int CBR_COND_W      = 4;
    localparam int CBR_JUMP_OFFSET = 8;
    localparam int CBR_JUMP_BITS   = 8;
    localparam int CBR_IDX_W       = 8;
endpackage

// File: rtl/cbr_imm_shape.sv
// Module: builds the 64-bit branch constant from the immediate.
// What it does: sign-extends the immediate, sets bit b and clears bit b-1,
// where b = cond + JUMP_OFFSET.
// Assumes: b stays inside the data word (checked at the top).
module cbr_imm_shape #(
    parameter int DATA_W      = cbr_pkg::CBR_DATA_W,
    parameter int IMM_W       = cbr_pkg::CBR_IMM_W,
    parameter int COND_W      = cbr_pkg::CBR_COND_W,
    parameter int JUMP_OFFSET = cbr_pkg::CBR_JUMP_OFFSET
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [COND_W-1:0] cond,
    output logic [DATA_W-1:0] cimm
);
    localparam int POS_W = $clog2(DATA_W);

    logic [POS_W-1:0] bpos;

    // Purpose: derive the forced bit position from the selector.
    always_comb begin
        bpos = POS_W'(cond) + POS_W'(JUMP_OFFSET);
    end

    // Purpose: sign-extend, then force bit b high and bit b-1 low.
    always_comb begin
        cimm = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        cimm[bpos] = 1'b1;
        if (bpos != '0) begin
            cimm[bpos - POS_W'(1)] = 1'b0;
        end
    end
endmodule

// File: rtl/cbr_window_zero.sv
// Module: tests a JUMP_BITS-wide window of a word for all zeros.
// What it does: the window starts at bit cond + JUMP_OFFSET; the output is 1
// when every bit in it is zero.
// Assumes: the window lies inside the word (checked at the top).
module cbr_window_zero #(
    parameter int DATA_W      = cbr_pkg::CBR_DATA_W,
    parameter int COND_W      = cbr_pkg::CBR_COND_W,
    parameter int JUMP_OFFSET = cbr_pkg::CBR_JUMP_OFFSET,
    parameter int JUMP_BITS   = cbr_pkg::CBR_JUMP_BITS
) (
    input  logic [DATA_W-1:0] value,
    input  logic [COND_W-1:0] cond,
    output logic              zero
);
    localparam int POS_W = $clog2(DATA_W);

    logic [POS_W-1:0]  bpos;
    logic [DATA_W-1:0] aligned;

    // Purpose: shift the window down to bit zero and reduce it.
    always_comb begin
        bpos    = POS_W'(cond) + POS_W'(JUMP_OFFSET);
        aligned = value >> bpos;
        zero    = ~|aligned[JUMP_BITS-1:0];
    end
endmodule

// File: rtl/cbr_eval.sv
// Module: conditional branch immediate evaluator (top).
// What it does: on in_valid, shapes the immediate, adds it to the register
// value, tests the window of the sum and registers sum, decision and target.
// Assumes: synchronous active-low reset; the caller writes out_sum back to
// the register file whatever out_taken says.
module cbr_eval #(
    parameter int DATA_W      = cbr_pkg::CBR_DATA_W,
    parameter int IMM_W       = cbr_pkg::CBR_IMM_W,
    parameter int COND_W      = cbr_pkg::CBR_COND_W,
    parameter int JUMP_OFFSET = cbr_pkg::CBR_JUMP_OFFSET,
    parameter int JUMP_BITS   = cbr_pkg::CBR_JUMP_BITS,
    parameter int IDX_W       = cbr_pkg::CBR_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [COND_W-1:0] in_cond,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [IDX_W-1:0]  in_target,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sum,
    output logic              out_taken,
    output logic [IDX_W-1:0]  out_target
);
    localparam int POS_W   = $clog2(DATA_W);
    localparam int TOP_BIT = (1 << COND_W) - 1 + JUMP_OFFSET + JUMP_BITS - 1;
    localparam int LOW_W   = JUMP_OFFSET - 1;
    localparam logic [DATA_W-1:0] WIN_ONES = {{(DATA_W-JUMP_BITS){1'b0}}, {JUMP_BITS{1'b1}}};

    // Purpose: reject parameter sets whose window would leave the word.
    if (TOP_BIT > DATA_W - 1 || IMM_W > DATA_W) begin : g_bad_params
        $error("cbr_eval: window top bit %0d exceeds word", TOP_BIT);
    end

    logic [DATA_W-1:0] cimm;
    logic [DATA_W-1:0] sum_c;
    logic              zero_c;

    cbr_imm_shape #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .COND_W(COND_W), .JUMP_OFFSET(JUMP_OFFSET)
    ) i_shape (
        .imm(in_imm), .cond(in_cond), .cimm(cimm)
    );

    // Purpose: modulo-2^DATA_W update of the register value.
    always_comb begin
        sum_c = in_dst + cimm;
    end

    cbr_window_zero #(
        .DATA_W(DATA_W), .COND_W(COND_W), .JUMP_OFFSET(JUMP_OFFSET), .JUMP_BITS(JUMP_BITS)
    ) i_window (
        .value(sum_c), .cond(in_cond), .zero(zero_c)
    );

    // Purpose: output valid follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Purpose: capture sum, decision and gated target on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sum    <= '0;
            out_taken  <= 1'b0;
            out_target <= '0;
        end else if (in_valid) begin
            out_sum    <= sum_c;
            out_taken  <= zero_c;
            out_target <= zero_c ? in_target : '0;
        end
    end

    assert_valid_follows_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_window_decision_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_taken ==
            (((out_sum >> (POS_W'($past(in_cond)) + POS_W'(JUMP_OFFSET))) & WIN_ONES) == '0)));

    assert_target_taken_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_taken) |-> (out_target == $past(in_target)));
    assert_target_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |-> (out_target == '0));

    assert_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sum) && $stable(out_taken) && $stable(out_target)));

    // Bits below b-1 of the constant are plain immediate bits, so the low sum bits
    // must match the low bits of register plus immediate.
    if (LOW_W > 0) begin : g_low_check
        assert_low_bits_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_sum[LOW_W-1:0] ==
                LOW_W'($past(in_dst[LOW_W-1:0]) + $past(in_imm[LOW_W-1:0]))));
    end
endmodule

// File: tb/test_cbr_eval.sv
`timescale 1ns/1ps
module test_cbr_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_imm = '0;
    logic [3:0]  in_cond = '0;
    logic [63:0] in_dst = '0;
    logic [7:0]  in_target = '0;
    logic        out_valid;
    logic [63:0] out_sum;
    logic        out_taken;
    logic [7:0]  out_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cbr_eval i_cbr_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_imm(in_imm),
        .in_cond(in_cond), .in_dst(in_dst), .in_target(in_target),
        .out_valid(out_valid), .out_sum(out_sum), .out_taken(out_taken),
        .out_target(out_target)
    );

    function automatic logic [63:0] exp_cimm(input logic [31:0] imm, input logic [3:0] cond);
        logic [63:0] c;
        int b;
        b = int'(cond) + 8;
        c = {{32{imm[31]}}, imm};
        c[b] = 1'b1;
        c[b-1] = 1'b0;
        return c;
    endfunction

    function automatic logic [63:0] win_mask(input logic [3:0] cond);
        return 64'hFF << (int'(cond) + 8);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one instruction after a falling edge, read results at the next one.
    task automatic send(input string req, input logic [31:0] imm, input logic [3:0] cond,
                        input logic [63:0] dst, input logic [7:0] tgt);
        logic [63:0] es;
        logic        et;
        es = dst + exp_cimm(imm, cond);
        et = ((es & win_mask(cond)) == 64'd0);
        @(negedge clk);
        in_valid = 1'b1; in_imm = imm; in_cond = cond; in_dst = dst; in_target = tgt;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {127'd0, out_valid}, {127'd0, 1'b1});
        check({req, " sum"}, {64'd0, out_sum}, {64'd0, es});
        check({req, " taken"}, {127'd0, out_taken}, {127'd0, et});
        check({req, " target"}, {120'd0, out_target}, {120'd0, (et ? tgt : 8'd0)});
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] r64, want, hs;
        logic        ht;
        logic [7:0]  hg;
        logic [3:0]  c;
        logic [31:0] im;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {62'd0, out_valid, out_taken, out_sum}, 128'd0);
        check("R1 reset target", {120'd0, out_target}, 128'd0);
        rst_n = 1'b1;

        // R3 R5: cond 15, zero inputs: bit 23 set, window not clear
        send("R3 R5 cond15 zero", 32'd0, 4'd15, 64'd0, 8'h11);
        check("R3 const bit", {64'd0, out_sum}, {64'd0, 64'h0000_0000_0080_0000});
        // R5 R7: cond 15, window 0x7F800000 clear, bits outside set
        want = 64'h0000_0000_8040_0001;
        send("R5 R7 cond15 taken", 32'h1234_5678, 4'd15, want - exp_cimm(32'h1234_5678, 4'd15), 8'h5A);
        check("R5 mask15 sum", {64'd0, out_sum}, {64'd0, want});
        check("R7 target taken", {120'd0, out_target}, {120'd0, 8'h5A});
        // R5: cond 4, mask 0x000FF000 clear
        want = 64'h0000_0000_00F0_0FFF;
        send("R5 cond4 taken", 32'h0BAD_F00D, 4'd4, want - exp_cimm(32'h0BAD_F00D, 4'd4), 8'h33);
        check("R5 mask4 taken", {127'd0, out_taken}, {127'd0, 1'b1});
        // R4: wrap around 2^64
        send("R4 wrap", 32'h0000_0001, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h44);
        check("R4 wrap sum", {64'd0, out_sum}, {64'd0, 64'h0000_0000_0000_0100});
        // R4: sign extension of a negative immediate
        send("R4 sext", 32'h8000_0000, 4'd0, 64'd0, 8'h01);
        check("R4 sext sum", {64'd0, out_sum}, {64'd0, 64'hFFFF_FFFF_8000_0100});
        // R3: bit b-1 cleared
        send("R3 clear below", 32'hFFFF_FFFF, 4'd0, 64'd0, 8'h02);
        check("R3 clear sum", {64'd0, out_sum}, {64'd0, 64'hFFFF_FFFF_FFFF_FF7F});
        // R6 R7: not taken still updates sum, target zero
        send("R6 R7 not taken", 32'h0000_0000, 4'd7, 64'h1111_2222_3333_4444, 8'hEE);
        check("R6 sum written", {64'd0, out_sum}, {64'd0, 64'h1111_2222_3333_4444 + exp_cimm(32'd0, 4'd7)});
        check("R7 target zero", {120'd0, out_target}, 128'd0);

        // R2 R8: idle cycles, valid drops and outputs hold
        hs = out_sum; ht = out_taken; hg = out_target;
        repeat (2) @(negedge clk);
        check("R2 idle valid", {127'd0, out_valid}, 128'd0);
        check("R8 hold", {55'd0, ht, hg, hs}, {55'd0, out_taken, out_target, out_sum});

        // Random mix, half steered into a zero window (R3 R5 R7)
        for (int i = 0; i < 300; i++) begin
            c  = 4'($urandom);
            im = $urandom;
            r64 = {$urandom, $urandom};
            if ($urandom % 2 == 0) begin
                r64 = (r64 & ~win_mask(c)) - exp_cimm(im, c);
            end
            send("R3 R5 R7 random", im, c, r64, 8'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule